// File: doc/BRIEF.md
# I2C Transfer Length and End Controller

This block sits beside a byte-level I2C engine and decides what happens when a programmed burst of bytes runs out. Software writes one word that holds an 8-bit byte count and five control bits: automatic end, reload, STOP request, slave NACK request and PEC byte request. The engine reports each finished byte with a one-cycle strobe, and the block counts the burst down.

When the last byte of a burst completes, the block does one of three things. It pulses a STOP request for the engine. It raises a transfer-complete flag and holds SCL low. Or, in reload mode, it raises a reload flag, holds SCL low and waits for a new count. It also decides, cycle by cycle, whether the engine answers the received byte with ACK or NACK. That decision depends on the role (master or slave), the position of the byte in the burst, an overrun, and the outcome of the PEC check.

Bit timing, address matching and CRC arithmetic stay outside the block. They arrive only as strobes and level inputs.

Top module: `i2c_burst_end_ctrl`

## Requirements
- R1: After reset, `count_left` is 0 and `stop_auto`, `tc_flag`, `tcr_flag`, `scl_stretch`, `stop_req_o`, `nack_req_o` and `pec_req_o` are all 0. A write (`wr_en` while `enable` is high) loads `wr_data[7:0]` into the count and loads `wr_data[8]` (automatic end) and `wr_data[9]` (reload) directly. The new count appears on `count_left` one cycle later.
- R2: A `byte_done` strobe decrements a non-zero count if `is_master` is high, or if `slave_byte_ctrl` is high. In slave mode without slave byte control, the count does not change.
- R3: With reload clear and automatic end set, in master mode, the strobe that takes the count from 1 to 0 produces a one-cycle `stop_auto` pulse in the cycle where `count_left` becomes 0. No flag is set.
- R4: With reload clear and either automatic end clear or slave mode, the final strobe sets `tc_flag` and `scl_stretch`. Both stay set until `stop_det`, a write with the STOP bit set, or `start_pending`.
- R5: With reload set, the final strobe sets `tcr_flag` and `scl_stretch`, whatever the automatic end bit holds. A later accepted count write clears both from the following cycle. A `stop_det` also clears them.
- R6: `wr_data[10]` (STOP request), `wr_data[11]` (NACK request) and `wr_data[12]` (PEC byte request) are set-only: writing 1 sets the bit and writing 0 leaves it unchanged.
- R7: Hardware clears the request bits as follows:
  - The STOP request clears on `stop_det`.
  - The NACK request clears on `nack_sent`, `stop_det` or `addr_match`.
  - The PEC request clears on `pec_done`, `stop_det` or `addr_match`.
- R8: `pec_send` is high exactly when the PEC request is set and reload is clear.
- R9: In master receive mode, `nack_out` is 1 only while `count_left` is 1 and reload is clear. The NACK request bit does not affect it.
- R10: In slave receive mode:
  - `nack_out` follows the NACK request bit.
  - An `overrun` while `no_stretch` is high forces `nack_out` to 1.
  - While `pec_send` is high and `count_left` is 1, `nack_out` follows `crc_bad` instead of the NACK request bit.
  - When not receiving, `nack_out` is 0.
- R11: While `start_pending` is high, a write leaves the count unchanged. The other bits of the write still take effect.
- R12: While `enable` is low, writes are ignored, and the flags and the three request bits are cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 13 | Control word: count [7:0], auto end [8], reload [9], stop [10], nack [11], pec [12] |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| is_rx | input | 1 | 1 = current byte is received |
| slave_byte_ctrl | input | 1 | Slave mode uses the byte count |
| no_stretch | input | 1 | Clock stretching disabled |
| start_pending | input | 1 | A START or repeated START is pending |
| byte_done | input | 1 | One-cycle strobe: a byte finished |
| stop_det | input | 1 | STOP condition detected |
| addr_match | input | 1 | Own address matched |
| nack_sent | input | 1 | A NACK was sent |
| pec_done | input | 1 | PEC byte transferred |
| overrun | input | 1 | Slave receive overrun |
| crc_bad | input | 1 | Received PEC does not match |
| count_left | output | 8 | Remaining byte count |
| stop_auto | output | 1 | One-cycle automatic STOP request |
| tc_flag | output | 1 | Transfer complete |
| tcr_flag | output | 1 | Transfer complete, reload pending |
| scl_stretch | output | 1 | Hold SCL low |
| stop_req_o | output | 1 | Software STOP request bit |
| nack_req_o | output | 1 | Software NACK request bit |
| pec_req_o | output | 1 | Software PEC byte request bit |
| pec_send | output | 1 | PEC byte active for this burst |
| nack_out | output | 1 | 1 = answer the current received byte with NACK |

## Verification
The end-of-burst decision is tried with a vector table that crosses three conditions: automatic end set or clear, reload set or clear, and master role versus slave role with byte control. The burst lengths are 1, 2, 3, 4 and 255. These combinations tell the STOP pulse apart from the complete flag and the reload flag, and they show that automatic end is ignored both under reload and in slave mode. Directed sequences then cover the following:
- writes that should fail to change the count (start pending, disabled, slave without byte control);
- each hardware clear source of each request bit;
- the ACK decision with the NACK request bit set against the master last-byte rule, the overrun override and the PEC check result.

// File: rtl/i2c_burst_pkg.sv
package i2c_burst_pkg;

    // Control bit offsets, counted above the byte count field
    localparam int OFS_AUTO   = 0;
    localparam int OFS_RELOAD = 1;
    localparam int OFS_STOP   = 2;
    localparam int OFS_NACK   = 3;
    localparam int OFS_PEC    = 4;
    localparam int CTRL_BITS  = 5;

    typedef enum logic [1:0] {
        END_TC     = 2'd0,
        END_STOP   = 2'd1,
        END_RELOAD = 2'd2
    } end_action_e;

    typedef struct packed {
        logic auto_end;
        logic reload;
        logic stop_req;
        logic nack_req;
        logic pec_req;
    } ctrl_t;

endpackage

// File: rtl/i2c_burst_cfg.sv
module i2c_burst_cfg
    import i2c_burst_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int WR_W = CNT_W + CTRL_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            stop_det,
    input  logic            addr_match,
    input  logic            nack_sent,
    input  logic            pec_done,
    output ctrl_t           ctrl
);

    ctrl_t ctrl_d, ctrl_q;
    logic  wr_ok;

    assign wr_ok = wr_en && enable;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ok) begin
            ctrl_d.auto_end = wr_data[CNT_W + OFS_AUTO];
            ctrl_d.reload   = wr_data[CNT_W + OFS_RELOAD];
            if (wr_data[CNT_W + OFS_STOP]) ctrl_d.stop_req = 1'b1;
            if (wr_data[CNT_W + OFS_NACK]) ctrl_d.nack_req = 1'b1;
            if (wr_data[CNT_W + OFS_PEC])  ctrl_d.pec_req  = 1'b1;
        end
        // hardware clears take priority over a same-cycle software set
        if (stop_det) begin
            ctrl_d.stop_req = 1'b0;
        end
        if (stop_det || addr_match || nack_sent) begin
            ctrl_d.nack_req = 1'b0;
        end
        if (stop_det || addr_match || pec_done) begin
            ctrl_d.pec_req = 1'b0;
        end
        if (!enable) begin
            ctrl_d.stop_req = 1'b0;
            ctrl_d.nack_req = 1'b0;
            ctrl_d.pec_req  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/i2c_burst_counter.sv
module i2c_burst_counter
    import i2c_burst_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop_wr,
    input  logic             byte_done,
    input  logic             count_active,
    input  logic             is_master,
    input  logic             auto_end,
    input  logic             reload,
    input  logic             stop_det,
    input  logic             start_pending,
    output logic [CNT_W-1:0] count,
    output logic             stop_pulse,
    output logic             tc,
    output logic             tcr
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tc;
        logic             tcr;
        logic             stop_pulse;
    } cnt_state_t;

    cnt_state_t  st_d, st_q;
    end_action_e action;

    always_comb begin
        if (reload) begin
            action = END_RELOAD;
        end else if (is_master && auto_end) begin
            action = END_STOP;
        end else begin
            action = END_TC;
        end
    end

    always_comb begin
        st_d            = st_q;
        st_d.stop_pulse = 1'b0;
        if (!enable) begin
            st_d.tc  = 1'b0;
            st_d.tcr = 1'b0;
        end else begin
            if (stop_det || stop_wr || start_pending) begin
                st_d.tc = 1'b0;
            end
            if (stop_det) begin
                st_d.tcr = 1'b0;
            end
            if (load) begin
                st_d.cnt = load_val;
                st_d.tcr = 1'b0;
            end else if (byte_done && count_active && (st_q.cnt != '0)) begin
                st_d.cnt = st_q.cnt - ONE;
                if (st_q.cnt == ONE) begin
                    unique case (action)
                        END_RELOAD: st_d.tcr        = 1'b1;
                        END_STOP:   st_d.stop_pulse = 1'b1;
                        default:    st_d.tc         = 1'b1;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.cnt;
    assign stop_pulse = st_q.stop_pulse;
    assign tc         = st_q.tc;
    assign tcr        = st_q.tcr;

endmodule

// File: rtl/i2c_burst_ack.sv
module i2c_burst_ack #(
    parameter int CNT_W = 8
) (
    input  logic             is_master,
    input  logic             is_rx,
    input  logic             no_stretch,
    input  logic             overrun,
    input  logic             crc_bad,
    input  logic             reload,
    input  logic             nack_req,
    input  logic             pec_active,
    input  logic [CNT_W-1:0] count,
    output logic             nack
);

    logic last_byte;

    assign last_byte = (count == CNT_W'(1));

    always_comb begin
        if (!is_rx) begin
            nack = 1'b0;
        end else if (is_master) begin
            nack = last_byte && !reload;
        end else if (overrun && no_stretch) begin
            nack = 1'b1;
        end else if (pec_active && last_byte) begin
            nack = crc_bad;
        end else begin
            nack = nack_req;
        end
    end

endmodule

// File: rtl/i2c_burst_end_ctrl.sv
module i2c_burst_end_ctrl
    import i2c_burst_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int WR_W = CNT_W + CTRL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             is_master,
    input  logic             is_rx,
    input  logic             slave_byte_ctrl,
    input  logic             no_stretch,
    input  logic             start_pending,
    input  logic             byte_done,
    input  logic             stop_det,
    input  logic             addr_match,
    input  logic             nack_sent,
    input  logic             pec_done,
    input  logic             overrun,
    input  logic             crc_bad,
    output logic [CNT_W-1:0] count_left,
    output logic             stop_auto,
    output logic             tc_flag,
    output logic             tcr_flag,
    output logic             scl_stretch,
    output logic             stop_req_o,
    output logic             nack_req_o,
    output logic             pec_req_o,
    output logic             pec_send,
    output logic             nack_out
);

    ctrl_t ctrl;
    logic  cnt_load;
    logic  stop_wr;
    logic  count_active;
    logic  pec_active;

    assign cnt_load     = wr_en && enable && !start_pending;
    assign stop_wr      = wr_en && enable && wr_data[CNT_W + OFS_STOP];
    assign count_active = is_master || slave_byte_ctrl;
    assign pec_active   = ctrl.pec_req && !ctrl.reload;

    i2c_burst_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .stop_det   (stop_det),
        .addr_match (addr_match),
        .nack_sent  (nack_sent),
        .pec_done   (pec_done),
        .ctrl       (ctrl)
    );

    i2c_burst_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .load          (cnt_load),
        .load_val      (wr_data[CNT_W-1:0]),
        .stop_wr       (stop_wr),
        .byte_done     (byte_done),
        .count_active  (count_active),
        .is_master     (is_master),
        .auto_end      (ctrl.auto_end),
        .reload        (ctrl.reload),
        .stop_det      (stop_det),
        .start_pending (start_pending),
        .count         (count_left),
        .stop_pulse    (stop_auto),
        .tc            (tc_flag),
        .tcr           (tcr_flag)
    );

    i2c_burst_ack #(.CNT_W(CNT_W)) u_ack (
        .is_master  (is_master),
        .is_rx      (is_rx),
        .no_stretch (no_stretch),
        .overrun    (overrun),
        .crc_bad    (crc_bad),
        .reload     (ctrl.reload),
        .nack_req   (ctrl.nack_req),
        .pec_active (pec_active),
        .count      (count_left),
        .nack       (nack_out)
    );

    assign scl_stretch = tc_flag || tcr_flag;
    assign stop_req_o  = ctrl.stop_req;
    assign nack_req_o  = ctrl.nack_req;
    assign pec_req_o   = ctrl.pec_req;
    assign pec_send    = pec_active;

endmodule

// File: rtl/i2c_burst_end_chk.sv
module i2c_burst_end_chk #(
    parameter int CNT_W = 8,
    parameter int WR_W  = CNT_W + 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             wr_en,
    input logic [WR_W-1:0]  wr_data,
    input logic             is_master,
    input logic             is_rx,
    input logic             slave_byte_ctrl,
    input logic             start_pending,
    input logic             byte_done,
    input logic             stop_det,
    input logic [CNT_W-1:0] count_left,
    input logic             stop_auto,
    input logic             tc_flag,
    input logic             tcr_flag,
    input logic             scl_stretch,
    input logic             stop_req_o,
    input logic             nack_req_o,
    input logic             pec_req_o,
    input logic             nack_out
);

    // R3
    stop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_auto |=> !stop_auto);

    // R3
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_auto |-> (count_left == '0) && !tc_flag);

    // R5
    tcr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tcr_flag) |-> (count_left == '0) && scl_stretch);

    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !slave_byte_ctrl && !wr_en) |=> $stable(count_left));

    // R11
    start_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pending && !byte_done) |=> $stable(count_left));

    // R7
    stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stop_req_o);

    // R12
    disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tc_flag && !tcr_flag && !stop_req_o && !nack_req_o && !pec_req_o);

    // R9
    master_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rx && is_master && (count_left != CNT_W'(1))) |-> !nack_out);

endmodule

bind i2c_burst_end_ctrl i2c_burst_end_chk #(.CNT_W(CNT_W), .WR_W(WR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .is_master       (is_master),
    .is_rx           (is_rx),
    .slave_byte_ctrl (slave_byte_ctrl),
    .start_pending   (start_pending),
    .byte_done       (byte_done),
    .stop_det        (stop_det),
    .count_left      (count_left),
    .stop_auto       (stop_auto),
    .tc_flag         (tc_flag),
    .tcr_flag        (tcr_flag),
    .scl_stretch     (scl_stretch),
    .stop_req_o      (stop_req_o),
    .nack_req_o      (nack_req_o),
    .pec_req_o       (pec_req_o),
    .nack_out        (nack_out)
);

// File: tb/i2c_burst_end_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_burst_end_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [12:0] wr_data = '0;
    logic        is_master = 1'b1;
    logic        is_rx = 1'b0;
    logic        slave_byte_ctrl = 1'b0;
    logic        no_stretch = 1'b0;
    logic        start_pending = 1'b0;
    logic        byte_done = 1'b0;
    logic        stop_det = 1'b0;
    logic        addr_match = 1'b0;
    logic        nack_sent = 1'b0;
    logic        pec_done = 1'b0;
    logic        overrun = 1'b0;
    logic        crc_bad = 1'b0;
    logic [7:0]  count_left;
    logic        stop_auto, tc_flag, tcr_flag, scl_stretch;
    logic        stop_req_o, nack_req_o, pec_req_o, pec_send, nack_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_burst_end_ctrl u_i2c_burst_end_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
        .is_master(is_master), .is_rx(is_rx), .slave_byte_ctrl(slave_byte_ctrl),
        .no_stretch(no_stretch), .start_pending(start_pending), .byte_done(byte_done),
        .stop_det(stop_det), .addr_match(addr_match), .nack_sent(nack_sent),
        .pec_done(pec_done), .overrun(overrun), .crc_bad(crc_bad),
        .count_left(count_left), .stop_auto(stop_auto), .tc_flag(tc_flag),
        .tcr_flag(tcr_flag), .scl_stretch(scl_stretch), .stop_req_o(stop_req_o),
        .nack_req_o(nack_req_o), .pec_req_o(pec_req_o), .pec_send(pec_send),
        .nack_out(nack_out)
    );

    // vector: {cnt[14:7], auto[6], reload[5], master[4], sbc[3], exp_stop[2], exp_tc[1], exp_tcr[0]}
    localparam int NVEC = 6;
    localparam logic [14:0] VEC [NVEC] = '{
        {8'd3,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd2,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd1,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd4,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd2,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'd255, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // control word: {pec, nack, stop, reload, auto, count}
    task automatic wr(input logic [7:0] c, input bit a, input bit r,
                      input bit s, input bit n, input bit p);
        wr_en   = 1'b1;
        wr_data = {p, n, s, r, a, c};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_byte();
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_det = 1'b1;
        @(negedge clk);
        stop_det = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 reset count", int'(count_left), 0);
        chk_eq("R1 reset flags",
               int'({stop_auto, tc_flag, tcr_flag, scl_stretch, stop_req_o, nack_req_o, pec_req_o}), 0);

        // table walk: R3 / R4 / R5 end actions
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            v = VEC[i];
            is_master       = v[4];
            slave_byte_ctrl = v[3];
            wr(v[14:7], v[6], v[5], 1'b0, 1'b0, 1'b0);
            chk_eq("R1 count load", int'(count_left), int'(v[14:7]));
            for (int b = 0; b < int'(v[14:7]); b++) pulse_byte();
            chk_eq("R3 stop pulse", int'(stop_auto), int'(v[2]));
            chk_eq("R4 tc flag", int'(tc_flag), int'(v[1]));
            chk_eq("R5 tcr flag", int'(tcr_flag), int'(v[0]));
            chk_eq("R4 R5 stretch", int'(scl_stretch), int'(v[1] | v[0]));
            chk_eq("R2 count zero", int'(count_left), 0);
            @(negedge clk);
            chk_eq("R3 pulse single", int'(stop_auto), 0);
            pulse_stop();
            chk_eq("R4 stop_det clears", int'(scl_stretch), 0);
        end

        // R2: slave without byte control does not count
        is_master = 1'b0; slave_byte_ctrl = 1'b0;
        wr(8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_byte();
        chk_eq("R2 slave no count", int'(count_left), 5);

        // R5: new count write releases reload stretch
        is_master = 1'b1;
        wr(8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        pulse_byte();
        chk_eq("R5 tcr set", int'(tcr_flag), 1);
        wr(8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_eq("R5 tcr released", int'({tcr_flag, scl_stretch}), 0);
        chk_eq("R5 reload count", int'(count_left), 3);

        // R4: STOP bit write clears tc; R7 stop_det clears stop request
        wr(8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_byte();
        chk_eq("R4 tc set", int'(tc_flag), 1);
        wr(8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk_eq("R4 stop write clears tc", int'(tc_flag), 0);
        chk_eq("R6 stop set", int'(stop_req_o), 1);
        wr(8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_eq("R6 stop write zero", int'(stop_req_o), 1);
        pulse_stop();
        chk_eq("R7 stop cleared", int'(stop_req_o), 0);

        // R11: count locked while start pending; R4 start clears tc
        wr(8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_byte();
        start_pending = 1'b1;
        wr(8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_eq("R11 count locked", int'(count_left), 0);
        chk_eq("R4 start clears tc", int'(tc_flag), 0);
        start_pending = 1'b0;

        // R9: master receive NACK on last byte
        is_rx = 1'b1;
        wr(8'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        #2 chk_eq("R9 not last", int'(nack_out), 0);
        @(negedge clk);
        pulse_byte();
        #2 chk_eq("R9 last byte nack", int'(nack_out), 1);
        @(negedge clk);
        wr(8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        #2 chk_eq("R9 reload no nack", int'(nack_out), 0);
        @(negedge clk);
        pulse_stop();

        // R10: slave receive
        is_master = 1'b0;
        wr(8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        #2 chk_eq("R10 nack follows req", int'(nack_out), 1);
        @(negedge clk);
        wr(8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_eq("R6 nack write zero", int'(nack_req_o), 1);
        nack_sent = 1'b1; @(negedge clk); nack_sent = 1'b0;
        chk_eq("R7 nack_sent clears", int'(nack_req_o), 0);
        overrun = 1'b1; no_stretch = 1'b1;
        #2 chk_eq("R10 overrun forces nack", int'(nack_out), 1);
        no_stretch = 1'b0;
        #2 chk_eq("R10 overrun with stretch", int'(nack_out), 0);
        overrun = 1'b0;
        @(negedge clk);
        slave_byte_ctrl = 1'b1;
        wr(8'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk_eq("R8 pec send", int'(pec_send), 1);
        #2 chk_eq("R10 pec good ack", int'(nack_out), 0);
        crc_bad = 1'b1;
        #2 chk_eq("R10 pec bad nack", int'(nack_out), 1);
        crc_bad = 1'b0;
        @(negedge clk);
        wr(8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk_eq("R8 reload hides pec", int'({pec_send, pec_req_o}), 1);
        #2 chk_eq("R10 reload uses req", int'(nack_out), 1);
        @(negedge clk);
        pec_done = 1'b1; @(negedge clk); pec_done = 1'b0;
        chk_eq("R7 pec_done clears", int'(pec_req_o), 0);
        addr_match = 1'b1; @(negedge clk); addr_match = 1'b0;
        chk_eq("R7 addr_match clears nack", int'(nack_req_o), 0);
        is_rx = 1'b0;

        // R12: disable clears and ignores writes
        is_master = 1'b1;
        wr(8'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        pulse_byte();
        chk_eq("R12 setup", int'({tc_flag, stop_req_o, nack_req_o, pec_req_o}), 15);
        enable = 1'b0;
        wr(8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk_eq("R12 disabled clears", int'({tc_flag, stop_req_o, nack_req_o, pec_req_o}), 0);
        chk_eq("R12 write ignored", int'(count_left), 0);
        enable = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule